// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Arbitration

This block is a synchronous memory of 2048 words of 16 bits with two fully independent access ports, called left and right. Each port has its own word address, an enable, a read-enable that gates the read-valid signal, and two byte-lane write strobes, one per byte of the word. Read data appears one clock after the address is presented. Both ports may read any word, including the same word, in the same cycle.

When both ports present the same word address in one cycle and at least one of them writes, the access is a collision. An arbiter grants one port and raises a busy flag towards the other. A busy port's writes are dropped, and its read completes without a valid strobe, so it must be retried. By default the left port wins a fresh collision. A port that already held the word in the previous cycle keeps it for as long as the collision continues.

For words wider than 16 bits, several instances are ganged. One instance runs as master and drives its busy outputs. The others run as slaves, take those flags on their busy inputs and do no arbitration of their own, so every slice grants the same port.

Top module: `dual_port_arb_ram`

## Requirements
- R1: The memory stores 2048 words of 16 bits, each addressed by an 11-bit word address. A word written through either port reads back unchanged through either port.
- R2: Two reads of the same word in the same cycle both return valid data, and neither port's busy output rises.
- R3: The upper-byte write strobe (`*_we_hi`) writes only bits 15:8, and the lower-byte strobe (`*_we_lo`) writes only bits 7:0. The other byte of the word keeps its value.
- R4: A collision occurs when both enables are high, the addresses are equal and at least one port writes. In master mode a collision raises exactly one busy output. In a fresh collision the left port wins and `r_busy_out` rises. Outside a collision both busy outputs stay low.
- R5: Priority on a collision has three rules. A port that won a collision on a word in the previous cycle keeps winning while the collision on that word continues. Otherwise, a port that accessed the word without being busy in the previous cycle wins over one that did not. Otherwise the left port wins.
- R6: With its enable low, a port neither reads nor writes, whatever its write strobes are. Its read-valid output is low one cycle later, and it causes no busy flag on either port.
- R7: Read data and read-valid are registered and appear in the cycle after the request. With enable high and read-enable low, read-valid is low in the following cycle.
- R8: A write from a port whose effective busy is high leaves the memory unchanged. A read from a busy port gives read-valid low in the following cycle.
- R9: A write from one port and a read from the other port to the same word form a collision and are arbitrated. They are not resolved as a read-during-write. The losing reader gets read-valid low, and the winning writer's data is stored.
- R10: With `master_mode` low, both busy outputs are held low. Each port's effective busy is then taken from its busy input, and two ports addressing the same word raise no flag.
- R11: Synchronous active-high reset clears both read-valid outputs, both read-data outputs and the arbitration history. The memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: internal arbitration; 0: busy taken from inputs |
| l_en | input | 1 | Left port enable |
| l_oe | input | 1 | Left port read enable |
| l_we_hi | input | 1 | Left write strobe, bits 15:8 |
| l_we_lo | input | 1 | Left write strobe, bits 7:0 |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_busy_in | input | 1 | Left busy from a master (slave mode) |
| l_busy_out | output | 1 | Left busy flag (master mode) |
| l_rdata | output | 16 | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| r_en | input | 1 | Right port enable |
| r_oe | input | 1 | Right port read enable |
| r_we_hi | input | 1 | Right write strobe, bits 15:8 |
| r_we_lo | input | 1 | Right write strobe, bits 7:0 |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_busy_in | input | 1 | Right busy from a master (slave mode) |
| r_busy_out | output | 1 | Right busy flag (master mode) |
| r_rdata | output | 16 | Right read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
A write on one port and a read on the other port can land on the same word in the same cycle. The bench provokes this by driving the left port to write a fresh value and the right port to read that word in one vector. It judges the outcome from the busy flag sampled in that cycle, the right read-valid one cycle later, and a follow-up read that must return the left port's data. Collisions that last several cycles are driven back to back to judge the priority-holding rule, and each busy port's write is then read back to prove it was dropped.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int ADDR_W = 11;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = BYTE_W * LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [1:0] {
        SIDE_NONE  = 2'd0,
        SIDE_LEFT  = 2'd1,
        SIDE_RIGHT = 2'd2
    } side_e;

    // Full request of one port, as seen by the storage.
    typedef struct packed {
        logic              en;
        logic              oe;
        logic [LANES-1:0]  we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } port_req_t;

    // Reduced request, as seen by the arbiter.
    typedef struct packed {
        logic              en;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } arb_req_t;

    // One port's access in the previous cycle.
    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
    } hist_t;

    // The previous cycle's collision and its winner.
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        side_e             side;
    } coll_t;

    function automatic arb_req_t to_arb(port_req_t p);
        arb_req_t a;
        a.en   = p.en;
        a.wr   = |p.we;
        a.addr = p.addr;
        return a;
    endfunction

    function automatic side_e pick_winner(logic carry, side_e carry_side,
                                          logic l_held, logic r_held);
        if (carry)
            return carry_side;
        if (r_held && !l_held)
            return SIDE_RIGHT;
        return SIDE_LEFT;
    endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     master,
    input  arb_req_t l_req,
    input  arb_req_t r_req,
    input  logic     l_busy_in,
    input  logic     r_busy_in,
    output logic     l_busy,
    output logic     r_busy,
    output logic     l_busy_out,
    output logic     r_busy_out
);

    hist_t hist_l, hist_r;
    coll_t prev_coll;

    logic  same_addr, coll, l_held, r_held, carry;
    side_e winner;
    logic  arb_l_busy, arb_r_busy;

    always_comb begin
        same_addr  = (l_req.addr == r_req.addr);
        coll       = l_req.en && r_req.en && same_addr && (l_req.wr || r_req.wr);
        l_held     = hist_l.act && (hist_l.addr == l_req.addr);
        r_held     = hist_r.act && (hist_r.addr == r_req.addr);
        carry      = prev_coll.valid && (prev_coll.addr == l_req.addr);
        winner     = pick_winner(carry, prev_coll.side, l_held, r_held);
        arb_l_busy = coll && (winner == SIDE_RIGHT);
        arb_r_busy = coll && (winner == SIDE_LEFT);
        l_busy     = master ? arb_l_busy : l_busy_in;
        r_busy     = master ? arb_r_busy : r_busy_in;
        l_busy_out = master && arb_l_busy;
        r_busy_out = master && arb_r_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_l    <= '0;
            hist_r    <= '0;
            prev_coll <= '{valid: 1'b0, addr: '0, side: SIDE_NONE};
        end else begin
            hist_l    <= '{act: l_req.en && !l_busy, addr: l_req.addr};
            hist_r    <= '{act: r_req.en && !r_busy, addr: r_req.addr};
            prev_coll <= '{valid: coll && master, addr: l_req.addr, side: winner};
        end
    end

    AST_READ_PAIR_FREE: assert property (@(posedge clk) disable iff (rst)
        (master && l_req.en && r_req.en && same_addr && !l_req.wr && !r_req.wr)
        |-> (!l_busy_out && !r_busy_out)); // R2

    AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (rst)
        master |-> !(l_busy_out && r_busy_out)); // R4

    AST_IDLE_LEFT_FREE: assert property (@(posedge clk) disable iff (rst)
        (master && !l_req.en) |-> (!l_busy_out && !r_busy_out)); // R6

    AST_IDLE_RIGHT_FREE: assert property (@(posedge clk) disable iff (rst)
        (master && !r_req.en) |-> (!l_busy_out && !r_busy_out)); // R6

    AST_WINNER_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (master && coll && $past(master && coll && !rst) &&
         (l_req.addr == $past(l_req.addr)) && $past(r_busy_out))
        |-> r_busy_out); // R5

    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !master |-> (!l_busy_out && !r_busy_out)); // R10

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_req_t         req_l,
    input  port_req_t         req_r,
    input  logic              l_busy,
    input  logic              r_busy,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    logic l_rd_go, r_rd_go;
    assign l_rd_go = req_l.en && req_l.oe;
    assign r_rd_go = req_r.en && req_r.oe;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic              l_wr_go, r_wr_go;

        assign l_wr_go = req_l.en && !l_busy && req_l.we[g];
        assign r_wr_go = req_r.en && !r_busy && req_r.we[g];

        // Left write is applied last so it wins an unarbitrated slave-mode clash.
        always_ff @(posedge clk) begin
            if (r_wr_go)
                lane_mem[req_r.addr] <= req_r.wdata[g*BYTE_W +: BYTE_W];
            if (l_wr_go)
                lane_mem[req_l.addr] <= req_l.wdata[g*BYTE_W +: BYTE_W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                l_rdata[g*BYTE_W +: BYTE_W] <= '0;
                r_rdata[g*BYTE_W +: BYTE_W] <= '0;
            end else begin
                if (l_rd_go)
                    l_rdata[g*BYTE_W +: BYTE_W] <= lane_mem[req_l.addr];
                if (r_rd_go)
                    r_rdata[g*BYTE_W +: BYTE_W] <= lane_mem[req_r.addr];
            end
        end

        AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
            (req_l.en && req_l.we[g] && l_busy &&
             !(r_wr_go && (req_r.addr == req_l.addr)))
            |=> (lane_mem[$past(req_l.addr)] == $past(lane_mem[req_l.addr]))); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_rvalid <= 1'b0;
            r_rvalid <= 1'b0;
        end else begin
            l_rvalid <= l_rd_go && !l_busy;
            r_rvalid <= r_rd_go && !r_busy;
        end
    end

    AST_NO_OE_NO_VALID_L: assert property (@(posedge clk) disable iff (rst)
        !(req_l.en && req_l.oe) |=> !l_rvalid); // R7

    AST_NO_OE_NO_VALID_R: assert property (@(posedge clk) disable iff (rst)
        !(req_r.en && req_r.oe) |=> !r_rvalid); // R7

    AST_BUSY_READ_INVALID: assert property (@(posedge clk) disable iff (rst)
        (req_l.en && l_busy) |=> !l_rvalid); // R8

endmodule

// File: rtl/dual_port_arb_ram.sv
module dual_port_arb_ram
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_oe,
    input  logic              l_we_hi,
    input  logic              l_we_lo,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_en,
    input  logic              r_oe,
    input  logic              r_we_hi,
    input  logic              r_we_lo,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in,
    output logic              r_busy_out,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    port_req_t req_l, req_r;
    logic      l_busy, r_busy;

    assign req_l = '{en: l_en, oe: l_oe, we: {l_we_hi, l_we_lo}, addr: l_addr, wdata: l_wdata};
    assign req_r = '{en: r_en, oe: r_oe, we: {r_we_hi, r_we_lo}, addr: r_addr, wdata: r_wdata};

    dpr_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .master     (master_mode),
        .l_req      (to_arb(req_l)),
        .r_req      (to_arb(req_r)),
        .l_busy_in  (l_busy_in),
        .r_busy_in  (r_busy_in),
        .l_busy     (l_busy),
        .r_busy     (r_busy),
        .l_busy_out (l_busy_out),
        .r_busy_out (r_busy_out)
    );

    dpr_storage u_mem (
        .clk      (clk),
        .rst      (rst),
        .req_l    (req_l),
        .req_r    (req_r),
        .l_busy   (l_busy),
        .r_busy   (r_busy),
        .l_rdata  (l_rdata),
        .l_rvalid (l_rvalid),
        .r_rdata  (r_rdata),
        .r_rvalid (r_rvalid)
    );

endmodule

// File: tb/test_dual_port_arb_ram.sv
module test_dual_port_arb_ram;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 17;

    // ctl = {en, oe, we_hi, we_lo}
    typedef struct packed {
        logic [3:0]  lc;
        logic [10:0] la;
        logic [15:0] lw;
        logic [3:0]  rc;
        logic [10:0] ra;
        logic [15:0] rw;
        logic        lb;
        logic        rb;
        logic        lv;
        logic [15:0] ld;
        logic        rv;
        logic [15:0] rd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b1011, 11'h010, 16'hA1B2, 4'b0000, 11'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R1 write
        '{4'b1100, 11'h010, 16'h0000, 4'b1011, 11'h020, 16'hC3D4, 1'b0, 1'b0, 1'b1, 16'hA1B2, 1'b0, 16'h0000}, // R1 R7 readback
        '{4'b1100, 11'h010, 16'h0000, 4'b1100, 11'h010, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hA1B2, 1'b1, 16'hA1B2}, // R2 shared read
        '{4'b1010, 11'h020, 16'h5566, 4'b0000, 11'h000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R3 upper byte
        '{4'b1100, 11'h020, 16'h0000, 4'b1001, 11'h010, 16'h0077, 1'b0, 1'b0, 1'b1, 16'h55D4, 1'b0, 16'h0000}, // R3 lower byte
        '{4'b1100, 11'h010, 16'h0000, 4'b0000, 11'h000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hA177, 1'b0, 16'h0000}, // R3 merged word
        '{4'b1011, 11'h030, 16'h1111, 4'b1011, 11'h030, 16'h2222, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R4 fresh collision
        '{4'b1100, 11'h030, 16'h0000, 4'b1011, 11'h030, 16'h3333, 1'b0, 1'b1, 1'b1, 16'h1111, 1'b0, 16'h0000}, // R5 winner keeps
        '{4'b0000, 11'h000, 16'h0000, 4'b1100, 11'h030, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1111}, // R8 right writes dropped
        '{4'b1011, 11'h030, 16'h4444, 4'b1100, 11'h030, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1111}, // R5 holder wins
        '{4'b1100, 11'h030, 16'h0000, 4'b0000, 11'h000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1111, 1'b0, 16'h0000}, // R8 left write dropped
        '{4'b1011, 11'h040, 16'hBEEF, 4'b1100, 11'h040, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R9 write vs read
        '{4'b0000, 11'h000, 16'h0000, 4'b1100, 11'h040, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hBEEF}, // R9 writer stored
        '{4'b1000, 11'h040, 16'h0000, 4'b0011, 11'h040, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R7 R6 oe low, idle strobes
        '{4'b1100, 11'h040, 16'h0000, 4'b0000, 11'h000, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b0, 16'h0000}, // R6 nothing written
        '{4'b0011, 11'h040, 16'h0000, 4'b1011, 11'h040, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R6 idle left no busy
        '{4'b1100, 11'h040, 16'h0000, 4'b1100, 11'h040, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 16'h1234}  // R6 R2 readback
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        master_mode;
    logic        l_en, l_oe, l_we_hi, l_we_lo, l_busy_in;
    logic [10:0] l_addr;
    logic [15:0] l_wdata;
    logic        r_en, r_oe, r_we_hi, r_we_lo, r_busy_in;
    logic [10:0] r_addr;
    logic [15:0] r_wdata;
    logic        l_busy_out, l_rvalid, r_busy_out, r_rvalid;
    logic [15:0] l_rdata, r_rdata;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_port_arb_ram i_dual_port_arb_ram (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_oe(l_oe), .l_we_hi(l_we_hi), .l_we_lo(l_we_lo),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_busy_in(l_busy_in),
        .l_busy_out(l_busy_out), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_en(r_en), .r_oe(r_oe), .r_we_hi(r_we_hi), .r_we_lo(r_we_lo),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_busy_in(r_busy_in),
        .r_busy_out(r_busy_out), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] lc, input logic [10:0] la, input logic [15:0] lw,
                         input logic [3:0] rc, input logic [10:0] ra, input logic [15:0] rw);
        {l_en, l_oe, l_we_hi, l_we_lo} = lc;
        l_addr = la; l_wdata = lw;
        {r_en, r_oe, r_we_hi, r_we_lo} = rc;
        r_addr = ra; r_wdata = rw;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; master_mode = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
        drive(4'b0000, 11'h0, 16'h0, 4'b0000, 11'h0, 16'h0);
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 l_rvalid after reset", {15'b0, l_rvalid}, 16'h0);
        check("R11 r_rvalid after reset", {15'b0, r_rvalid}, 16'h0);
        check("R11 l_rdata after reset", l_rdata, 16'h0);
        check("R11 r_rdata after reset", r_rdata, 16'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            drive(v.lc, v.la, v.lw, v.rc, v.ra, v.rw);
            #1;
            check($sformatf("vec %0d l_busy_out", i), {15'b0, l_busy_out}, {15'b0, v.lb});
            check($sformatf("vec %0d r_busy_out", i), {15'b0, r_busy_out}, {15'b0, v.rb});
            @(negedge clk);
            check($sformatf("vec %0d l_rvalid", i), {15'b0, l_rvalid}, {15'b0, v.lv});
            check($sformatf("vec %0d r_rvalid", i), {15'b0, r_rvalid}, {15'b0, v.rv});
            if (v.lv) check($sformatf("vec %0d l_rdata", i), l_rdata, v.ld);
            if (v.rv) check($sformatf("vec %0d r_rdata", i), r_rdata, v.rd);
        end

        // R10 slave mode: seed a word in master mode first
        drive(4'b1011, 11'h050, 16'h0F0F, 4'b0000, 11'h0, 16'h0);
        @(negedge clk);
        master_mode = 1'b0;
        l_busy_in = 1'b1;
        drive(4'b1011, 11'h050, 16'h9999, 4'b1011, 11'h070, 16'h7777);
        #1;
        check("R10 slave l_busy_out low", {15'b0, l_busy_out}, 16'h0);
        check("R10 slave r_busy_out low", {15'b0, r_busy_out}, 16'h0);
        @(negedge clk);
        l_busy_in = 1'b0;
        drive(4'b1011, 11'h080, 16'hAAAA, 4'b1011, 11'h080, 16'h5555);
        #1;
        check("R10 slave same-word l_busy_out", {15'b0, l_busy_out}, 16'h0);
        check("R10 slave same-word r_busy_out", {15'b0, r_busy_out}, 16'h0);
        @(negedge clk);
        drive(4'b1100, 11'h050, 16'h0, 4'b1100, 11'h070, 16'h0);
        @(negedge clk);
        check("R10 R8 busy_in dropped left write", l_rdata, 16'h0F0F);
        check("R10 right write without busy_in", r_rdata, 16'h7777);
        l_busy_in = 1'b1;
        drive(4'b1100, 11'h050, 16'h0, 4'b0000, 11'h0, 16'h0);
        @(negedge clk);
        check("R8 busy read has rvalid low", {15'b0, l_rvalid}, 16'h0);
        l_busy_in = 1'b0;
        master_mode = 1'b1;

        // R11 reset in mid-run
        drive(4'b1100, 11'h070, 16'h0, 4'b1100, 11'h070, 16'h0);
        @(negedge clk);
        check("R11 pre-reset r_rdata", r_rdata, 16'h7777);
        rst = 1'b1;
        @(negedge clk);
        check("R11 l_rvalid cleared", {15'b0, l_rvalid}, 16'h0);
        check("R11 r_rdata cleared", r_rdata, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 memory kept", r_rdata, 16'h7777);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule